// File: doc/BRIEF.md
# Secondary Cache Request Sequencer

This block sits between a processor bus and a system bus in front of a direct-mapped, write-through secondary cache. For each processor request it decides whether the cache serves it or the system bus must. It also decides when the system-side strobes fire. The tag store is an external RAM with one entry per line, and each entry holds a valid bit and a tag. The block drives the entry index. It reads the entry combinationally in the cycle of the request and writes the entry when a line is filled or written.

The block uses fixed latencies for each kind of request. Writes, cached or not, go to the system in the cycle of the request. An uncached read goes one cycle later. A block read that misses goes two cycles later, together with a release strobe and the output enable of the latch that replays the held address and command. When the system returns the data for that miss, the block writes the whole line into the cache and then marks the entry valid. A block read that hits is served from the cache. Its data strobe comes one or two cycles after the request. The choice depends on a configuration pin that is sampled while reset is held.

External write and null requests from the system side pass straight through to the processor.

Top module: `l2_req_seq`

## Requirements
- R1: The read-hit wait state is enabled only if `wait_cfg_i` was high at each of the last four clock edges before `rst_n` rises. With the wait state off, `hit_data_o` pulses one cycle after a hitting block read is accepted. With it on, the pulse comes two cycles after. The setting holds until the next reset.
- R2: While `rst_n` is low, every strobe output is low. Reset clears only the sequencer, so an entry written before reset still hits afterwards.
- R3: A block read (command 2'b00) that hits never asserts `sys_valid_o`.
- R4: A block read that misses asserts `sys_valid_o`, `sys_release_o` and `latch_oe_o` together, for one cycle, exactly two cycles after the request.
- R5: During a miss fill, each `sys_ret_i` word asserts `cache_we_o` in the same cycle, with `cache_word_o` counting 0 to LINE_WORDS-1. The last word also asserts `tag_we_o`, with `tag_wr_vld_o` high and the request's tag and index.
- R6: An uncached read (command 2'b01) asserts `sys_valid_o` and `latch_oe_o` one cycle after the request, without `sys_release_o`. Its single returned word causes no cache or tag write.
- R7: A block write (command 2'b10) asserts `sys_valid_o` and `tag_we_o` (valid set, request tag) in the request cycle itself.
- R8: After a block write request, `cache_we_o` follows `cpu_wd_i` for exactly LINE_WORDS data words. The words may come densely or with idle cycles between them, and `cache_word_o` counts them. A data strobe after the last word writes nothing.
- R9: An uncached write (command 2'b11) asserts `sys_valid_o` in the request cycle and writes neither the cache nor the tag RAM.
- R10: A block read hits only if the entry's valid bit is set and its tag equals the request tag. The index is the low IDX_W bits of `cpu_line_i` and the tag is the upper TAG_W bits. A matching tag with the valid bit clear is a miss.
- R11: External requests with codes 2'b00 (write) and 2'b01 (null) raise `cpu_ext_valid_o` in the same cycle. Codes 2'b10 (read) and 2'b11 are dropped. Neither case disturbs a transfer in progress.
- R12: A processor request that arrives while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wait_cfg_i | input | 1 | Read-hit wait-state configuration pin, sampled during reset |
| cpu_valid_i | input | 1 | Processor request strobe |
| cpu_cmd_i | input | 2 | Request kind: 00 block read, 01 uncached read, 10 block write, 11 uncached write |
| cpu_line_i | input | TAG_W+IDX_W | Line address: tag above index |
| cpu_wd_i | input | 1 | Block-write data word valid |
| tag_idx_o | output | IDX_W | Tag RAM entry index |
| tag_rd_vld_i | input | 1 | Valid bit read from the tag RAM |
| tag_rd_tag_i | input | TAG_W | Tag read from the tag RAM |
| tag_we_o | output | 1 | Tag RAM write enable |
| tag_wr_vld_o | output | 1 | Valid bit to write |
| tag_wr_tag_o | output | TAG_W | Tag to write |
| cache_we_o | output | 1 | Data SRAM word write enable |
| cache_word_o | output | $clog2(LINE_WORDS) | Word position within the line |
| hit_data_o | output | 1 | Cache data strobe to the processor on a read hit |
| sys_valid_o | output | 1 | System-side request valid |
| sys_release_o | output | 1 | System-side release strobe on a read miss |
| latch_oe_o | output | 1 | Output enable of the address/command replay latch |
| sys_ret_i | input | 1 | System returns a read data word |
| ext_valid_i | input | 1 | External request strobe |
| ext_cmd_i | input | 2 | External request code |
| cpu_ext_valid_o | output | 1 | External request forwarded to the processor |

## Verification
External requests and a read-miss line fill can fall in the same cycle. The pass-through is purely combinational, while the fill is driven by the state machine. The bench provokes this by presenting a null, a write, a read and a reserved external code during the four fill cycles of a miss. It checks that only the first two reach the processor in their own cycle. It also checks that the fill still writes four words in order and sets the tag on the last one. A processor request raised while a miss is waiting to be forwarded is a second overlap. The bench judges that case by the forward strobe still landing in cycle 2.

// File: rtl/l2rs_pkg.sv
package l2rs_pkg;

    typedef enum logic [1:0] {
        REQ_BLK_RD = 2'b00,
        REQ_UNC_RD = 2'b01,
        REQ_BLK_WR = 2'b10,
        REQ_UNC_WR = 2'b11
    } req_e;

    typedef enum logic [1:0] {
        EXT_WRITE = 2'b00,
        EXT_NULL  = 2'b01,
        EXT_READ  = 2'b10,
        EXT_RSVD  = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIT,
        ST_FWD,
        ST_FILL,
        ST_WDATA
    } st_e;

endpackage

// File: rtl/l2rs_cfg_sample.sv
module l2rs_cfg_sample #(
    parameter int SAMPLE_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic mode_o
);
    logic [SAMPLE_N-1:0] hist_d, hist_q;

    // shift only while reset is held; freeze afterwards
    always_comb begin
        hist_d = hist_q;
        if (!rst_n) hist_d = {hist_q[SAMPLE_N-2:0], pin_i};
    end

    always_ff @(posedge clk) hist_q <= hist_d;

    assign mode_o = &hist_q;

    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_o));

endmodule

// File: rtl/l2rs_tag_match.sv
module l2rs_tag_match #(
    parameter int TAG_W = 17
) (
    input  logic             vld_i,
    input  logic [TAG_W-1:0] stored_i,
    input  logic [TAG_W-1:0] req_i,
    output logic             hit_o
);
    assign hit_o = vld_i && (stored_i == req_i);
endmodule

// File: rtl/l2_req_seq.sv
module l2_req_seq
    import l2rs_pkg::*;
#(
    parameter int TAG_W      = 17,
    parameter int IDX_W      = 10,
    parameter int LINE_WORDS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wait_cfg_i,
    input  logic                           cpu_valid_i,
    input  logic [1:0]                     cpu_cmd_i,
    input  logic [TAG_W+IDX_W-1:0]         cpu_line_i,
    input  logic                           cpu_wd_i,
    output logic [IDX_W-1:0]               tag_idx_o,
    input  logic                           tag_rd_vld_i,
    input  logic [TAG_W-1:0]               tag_rd_tag_i,
    output logic                           tag_we_o,
    output logic                           tag_wr_vld_o,
    output logic [TAG_W-1:0]               tag_wr_tag_o,
    output logic                           cache_we_o,
    output logic [$clog2(LINE_WORDS)-1:0]  cache_word_o,
    output logic                           hit_data_o,
    output logic                           sys_valid_o,
    output logic                           sys_release_o,
    output logic                           latch_oe_o,
    input  logic                           sys_ret_i,
    input  logic                           ext_valid_i,
    input  logic [1:0]                     ext_cmd_i,
    output logic                           cpu_ext_valid_o
);
    localparam int LINE_AW = TAG_W + IDX_W;
    localparam int CNT_W   = $clog2(LINE_WORDS);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(LINE_WORDS - 1);

    typedef struct packed {
        st_e              st;
        logic             miss;
        logic             dly;
        logic [CNT_W-1:0] cnt;
        logic [LINE_AW-1:0] line;
    } seq_t;

    seq_t d, q;
    req_e cmd;
    ext_e ecmd;
    logic wait_mode, hit, idle, accept;
    logic [TAG_W-1:0] req_tag, held_tag;
    logic [IDX_W-1:0] req_idx, held_idx;

    assign cmd      = req_e'(cpu_cmd_i);
    assign ecmd     = ext_e'(ext_cmd_i);
    assign req_tag  = cpu_line_i[LINE_AW-1 -: TAG_W];
    assign req_idx  = cpu_line_i[IDX_W-1:0];
    assign held_tag = q.line[LINE_AW-1 -: TAG_W];
    assign held_idx = q.line[IDX_W-1:0];
    assign idle     = (q.st == ST_IDLE);
    assign accept   = rst_n && idle && cpu_valid_i;

    l2rs_cfg_sample #(.SAMPLE_N(4)) u_cfg (
        .clk(clk), .rst_n(rst_n), .pin_i(wait_cfg_i), .mode_o(wait_mode)
    );

    l2rs_tag_match #(.TAG_W(TAG_W)) u_match (
        .vld_i(tag_rd_vld_i), .stored_i(tag_rd_tag_i), .req_i(req_tag), .hit_o(hit)
    );

    assign tag_idx_o       = idle ? req_idx : held_idx;
    assign tag_wr_tag_o    = idle ? req_tag : held_tag;
    assign tag_wr_vld_o    = tag_we_o;
    assign cache_word_o    = q.cnt;
    assign cpu_ext_valid_o = ext_valid_i && (ecmd == EXT_WRITE || ecmd == EXT_NULL);

    always_comb begin
        d             = q;
        tag_we_o      = 1'b0;
        cache_we_o    = 1'b0;
        hit_data_o    = 1'b0;
        sys_valid_o   = 1'b0;
        sys_release_o = 1'b0;
        latch_oe_o    = 1'b0;
        if (rst_n) begin
            unique case (q.st)
                ST_IDLE: if (cpu_valid_i) begin
                    d.line = cpu_line_i;
                    d.cnt  = '0;
                    unique case (cmd)
                        REQ_BLK_RD: begin
                            d.miss = !hit;
                            d.st   = hit ? ST_HIT : ST_FWD;
                            d.dly  = hit ? wait_mode : 1'b1;
                        end
                        REQ_UNC_RD: begin
                            d.miss = 1'b0;
                            d.st   = ST_FWD;
                            d.dly  = 1'b0;
                        end
                        REQ_BLK_WR: begin
                            sys_valid_o = 1'b1;
                            tag_we_o    = 1'b1;
                            d.st        = ST_WDATA;
                        end
                        REQ_UNC_WR: sys_valid_o = 1'b1;
                        default: d.st = ST_IDLE;
                    endcase
                end
                ST_HIT: begin
                    if (q.dly) d.dly = 1'b0;
                    else begin
                        hit_data_o = 1'b1;
                        d.st       = ST_IDLE;
                    end
                end
                ST_FWD: begin
                    if (q.dly) d.dly = 1'b0;
                    else begin
                        sys_valid_o   = 1'b1;
                        latch_oe_o    = 1'b1;
                        sys_release_o = q.miss;
                        d.st          = ST_FILL;
                    end
                end
                ST_FILL: if (sys_ret_i) begin
                    cache_we_o = q.miss;
                    d.cnt      = q.cnt + 1'b1;
                    if (!q.miss || q.cnt == LAST_WORD) begin
                        tag_we_o = q.miss;
                        d.st     = ST_IDLE;
                    end
                end
                ST_WDATA: if (cpu_wd_i) begin
                    cache_we_o = 1'b1;
                    d.cnt      = q.cnt + 1'b1;
                    if (q.cnt == LAST_WORD) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.miss <= 1'b0;
            q.dly  <= 1'b0;
            q.cnt  <= '0;
            q.line <= '0;
        end else begin
            q <= d;
        end
    end

    // ---------------- assertions ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_quiet_in_reset_r2: assert (!(tag_we_o || cache_we_o || hit_data_o ||
                                          sys_valid_o || sys_release_o || latch_oe_o));
        end
    end

    p_hit_no_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HIT) |-> !sys_valid_o);

    p_miss_two_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd == REQ_BLK_RD && !tag_rd_vld_i) |=> !sys_valid_o ##1
        (sys_valid_o && sys_release_o && latch_oe_o));

    p_release_replay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_release_o |-> (sys_valid_o && latch_oe_o));

    p_fill_tag_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_we_o && q.st == ST_FILL) |-> (cache_we_o && cache_word_o == LAST_WORD));

    p_unc_rd_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd == REQ_UNC_RD) |=> (sys_valid_o && latch_oe_o && !sys_release_o));

    p_unc_fill_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && !q.miss) |-> (!cache_we_o && !tag_we_o));

    p_bwr_same_cyc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd == REQ_BLK_WR) |-> (sys_valid_o && tag_we_o && tag_wr_vld_o));

    p_uwr_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd == REQ_UNC_WR) |-> (sys_valid_o && !tag_we_o && !cache_we_o));

    p_invalid_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd == REQ_BLK_RD && !tag_rd_vld_i) |=> (q.st == ST_FWD));

    p_ext_read_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid_i && (ecmd == EXT_READ || ecmd == EXT_RSVD)) |-> !cpu_ext_valid_o);

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WDATA) |-> (!sys_valid_o && !tag_we_o));

endmodule

// File: tb/l2_req_seq_test.sv
`timescale 1ns/1ps
module l2_req_seq_test;
    localparam int TAG_W = 17;
    localparam int IDX_W = 10;
    localparam int LW    = 4;
    localparam int LA    = TAG_W + IDX_W;
    localparam int CW    = $clog2(LW);
    localparam logic [1:0] BRD = 2'b00, URD = 2'b01, BWR = 2'b10, UWR = 2'b11;
    localparam logic [7:0] NO = 8'hFF;

    localparam logic [LA-1:0] LA_A = {17'd2, 10'h11A};
    localparam logic [LA-1:0] LA_B = {17'd3, 10'h11A};
    localparam logic [LA-1:0] LA_C = {17'd5, 10'h001};
    localparam logic [LA-1:0] LA_D = {17'd9, 10'h050};
    localparam logic [LA-1:0] LA_E = {17'd7, 10'h060};
    localparam logic [LA-1:0] LA_F = {17'd4, 10'h070};

    typedef struct packed {
        logic [1:0]    cmd;
        logic [LA-1:0] line;
        logic [7:0]    pat, fwd, rel, loe, hit, tagw, cwe;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{BRD, LA_A, 8'h00, 8'd2, 8'd2, 8'd2, NO,   8'd7, 8'd4},
        '{BRD, LA_A, 8'h00, NO,   NO,   NO,   8'd1, NO,   8'd0},
        '{URD, LA_B, 8'h00, 8'd1, NO,   8'd1, NO,   NO,   8'd0},
        '{BRD, LA_B, 8'h00, 8'd2, 8'd2, 8'd2, NO,   8'd7, 8'd4},
        '{BRD, LA_A, 8'h00, 8'd2, 8'd2, 8'd2, NO,   8'd7, 8'd4},
        '{BWR, LA_B, 8'h1F, 8'd0, NO,   NO,   NO,   8'd0, 8'd4},
        '{BRD, LA_B, 8'h00, NO,   NO,   NO,   8'd1, NO,   8'd0},
        '{UWR, LA_A, 8'h00, 8'd0, NO,   NO,   NO,   NO,   8'd0},
        '{BRD, LA_B, 8'h00, NO,   NO,   NO,   8'd1, NO,   8'd0},
        '{BWR, LA_A, 8'h55, 8'd0, NO,   NO,   NO,   8'd0, 8'd4},
        '{BRD, LA_A, 8'h00, NO,   NO,   NO,   8'd1, NO,   8'd0},
        '{BRD, LA_C, 8'h00, 8'd2, 8'd2, 8'd2, NO,   8'd7, 8'd4}
    };

    logic clk = 1'b0, rst_n = 1'b0, wait_cfg = 1'b0;
    logic cpu_valid = 1'b0, cpu_wd = 1'b0, sys_ret = 1'b0, ext_valid = 1'b0;
    logic [1:0] cpu_cmd = 2'b00, ext_cmd = 2'b00;
    logic [LA-1:0] cpu_line = '0;
    logic [IDX_W-1:0] tag_idx;
    logic tag_rd_vld, tag_we, tag_wr_vld, cache_we, hit_data;
    logic sys_valid, sys_release, latch_oe, cpu_ext_valid;
    logic [TAG_W-1:0] tag_rd_tag, tag_wr_tag;
    logic [CW-1:0] cache_word;

    logic [TAG_W:0] tmem [1 << IDX_W] = '{default: '0};
    logic pre_en = 1'b0;
    logic [IDX_W-1:0] pre_idx = '0;
    logic [TAG_W:0] pre_val = '0;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (pre_en)      tmem[pre_idx] <= pre_val;
        else if (tag_we) tmem[tag_idx] <= {tag_wr_vld, tag_wr_tag};
    end
    assign tag_rd_vld = tmem[tag_idx][TAG_W];
    assign tag_rd_tag = tmem[tag_idx][TAG_W-1:0];

    l2_req_seq #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_WORDS(LW)) uut (
        .clk(clk), .rst_n(rst_n), .wait_cfg_i(wait_cfg),
        .cpu_valid_i(cpu_valid), .cpu_cmd_i(cpu_cmd), .cpu_line_i(cpu_line), .cpu_wd_i(cpu_wd),
        .tag_idx_o(tag_idx), .tag_rd_vld_i(tag_rd_vld), .tag_rd_tag_i(tag_rd_tag),
        .tag_we_o(tag_we), .tag_wr_vld_o(tag_wr_vld), .tag_wr_tag_o(tag_wr_tag),
        .cache_we_o(cache_we), .cache_word_o(cache_word), .hit_data_o(hit_data),
        .sys_valid_o(sys_valid), .sys_release_o(sys_release), .latch_oe_o(latch_oe),
        .sys_ret_i(sys_ret), .ext_valid_i(ext_valid), .ext_cmd_i(ext_cmd),
        .cpu_ext_valid_o(cpu_ext_valid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ex(input logic [7:0] v);
        return (v == NO) ? -1 : int'(v);
    endfunction

    // pinpat bit i = pin level before the i-th reset edge (8 edges)
    task automatic do_reset(input logic [7:0] pinpat);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rst_n = 1'b0;
            wait_cfg = pinpat[i];
        end
        @(negedge clk);
        rst_n = 1'b1;
        wait_cfg = 1'b0;
    endtask

    task automatic preset(input logic [IDX_W-1:0] idx, input logic [TAG_W:0] val);
        @(negedge clk);
        pre_en = 1'b1; pre_idx = idx; pre_val = val;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic do_req(input logic [1:0] cmd, input logic [LA-1:0] line, input logic [7:0] pat,
                          input bit poke, input bit ext,
                          output int fwd, output int rel, output int loe, output int hit,
                          output int tagw, output int cwe, output int seqbad, output int extbad);
        int nret, given;
        bit ext_exp;
        fwd = -1; rel = -1; loe = -1; hit = -1; tagw = -1; cwe = 0; seqbad = 0; extbad = 0;
        given = 0;
        nret = (cmd == BRD) ? LW : ((cmd == URD) ? 1 : 0);
        for (int cyc = 0; cyc < 24; cyc++) begin
            @(negedge clk);
            cpu_valid = (cyc == 0) || (poke && cyc == 1);
            cpu_cmd   = (poke && cyc == 1) ? UWR : cmd;
            cpu_line  = line;
            cpu_wd    = 1'b0;
            if (cyc >= 1 && cyc <= 8) cpu_wd = pat[cyc-1];
            sys_ret = (fwd >= 0) && (cyc >= fwd + 2) && (given < nret);
            if (sys_ret) given++;
            ext_valid = ext && cyc >= 4 && cyc <= 7;
            ext_cmd   = 2'((cyc - 4) & 3);
            case (cyc)
                4: ext_cmd = 2'b01;
                5: ext_cmd = 2'b00;
                6: ext_cmd = 2'b10;
                7: ext_cmd = 2'b11;
                default: ext_cmd = 2'b00;
            endcase
            ext_exp = (cyc == 4 || cyc == 5);
            #3;
            if (sys_valid && fwd < 0)   fwd = cyc;
            if (sys_release && rel < 0) rel = cyc;
            if (latch_oe && loe < 0)    loe = cyc;
            if (hit_data && hit < 0)    hit = cyc;
            if (tag_we && tagw < 0)     tagw = cyc;
            if (cache_we) begin
                if (int'(cache_word) != (cwe % LW)) seqbad++;
                cwe++;
            end
            if (ext && cyc >= 4 && cyc <= 7 && cpu_ext_valid != ext_exp) extbad++;
        end
        @(negedge clk);
        cpu_valid = 1'b0; cpu_wd = 1'b0; sys_ret = 1'b0; ext_valid = 1'b0;
    endtask

    function automatic string lbl_fwd(input logic [1:0] c, input logic [7:0] h);
        case (c)
            BRD: return (h != NO) ? "R3" : "R4";
            URD: return "R6";
            BWR: return "R7";
            default: return "R9";
        endcase
    endfunction

    function automatic string lbl_cwe(input logic [1:0] c);
        case (c)
            BRD: return "R5";
            URD: return "R6";
            BWR: return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int f, r, l, h, t, c, sb, eb;
        // R2: strobes quiet during reset even with a request presented
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        cpu_valid = 1'b1; cpu_cmd = BWR; cpu_line = LA_A;
        #3;
        chk("R2", "strobes in reset", int'({tag_we, cache_we, hit_data, sys_valid, sys_release, latch_oe}), 0);
        @(negedge clk);
        cpu_valid = 1'b0;
        do_reset(8'h00);

        // table of vectors, wait state off
        for (int v = 0; v < NV; v++) begin
            do_req(VECS[v].cmd, VECS[v].line, VECS[v].pat, 1'b0, 1'b0, f, r, l, h, t, c, sb, eb);
            chk(lbl_fwd(VECS[v].cmd, VECS[v].hit), $sformatf("v%0d sys_valid cycle", v), f, ex(VECS[v].fwd));
            chk("R4", $sformatf("v%0d release cycle", v), r, ex(VECS[v].rel));
            chk((VECS[v].cmd == URD) ? "R6" : "R4", $sformatf("v%0d latch_oe cycle", v), l, ex(VECS[v].loe));
            chk("R3", $sformatf("v%0d hit cycle", v), h, ex(VECS[v].hit));
            chk((VECS[v].cmd == BWR) ? "R7" : "R5", $sformatf("v%0d tag write cycle", v), t, ex(VECS[v].tagw));
            chk(lbl_cwe(VECS[v].cmd), $sformatf("v%0d cache words", v), c, ex(VECS[v].cwe));
            chk(lbl_cwe(VECS[v].cmd), $sformatf("v%0d word order", v), sb, 0);
            if (VECS[v].tagw != NO)
                chk("R10", $sformatf("v%0d tag entry", v), int'(tmem[VECS[v].line[IDX_W-1:0]]),
                    int'({1'b1, VECS[v].line[LA-1 -: TAG_W]}));
        end

        // R10: matching tag but valid bit clear is a miss
        preset(LA_D[IDX_W-1:0], {1'b0, LA_D[LA-1 -: TAG_W]});
        do_req(BRD, LA_D, 8'h00, 1'b0, 1'b0, f, r, l, h, t, c, sb, eb);
        chk("R10", "invalid entry forward cycle", f, 2);
        chk("R10", "invalid entry no hit", h, -1);

        // R12: a request while a miss is pending is ignored
        do_req(BRD, LA_E, 8'h00, 1'b1, 1'b0, f, r, l, h, t, c, sb, eb);
        chk("R12", "forward cycle with busy poke", f, 2);
        chk("R12", "fill still completes", t, 7);

        // R11: external requests during a fill
        do_req(BRD, LA_F, 8'h00, 1'b0, 1'b1, f, r, l, h, t, c, sb, eb);
        chk("R11", "external pass/drop mismatches", eb, 0);
        chk("R11", "fill words beside external", c, 4);
        chk("R11", "fill word order beside external", sb, 0);
        chk("R11", "fill tag beside external", t, 7);

        // R1: pin high on the last four reset edges -> one wait state
        do_reset(8'hF0);
        do_req(BRD, LA_A, 8'h00, 1'b0, 1'b0, f, r, l, h, t, c, sb, eb);
        chk("R1", "hit cycle with wait state", h, 2);
        chk("R2", "entry survives reset (no forward)", f, -1);

        // R1: last sample low -> no wait state
        do_reset(8'h7F);
        do_req(BRD, LA_A, 8'h00, 1'b0, 1'b0, f, r, l, h, t, c, sb, eb);
        chk("R1", "hit cycle without wait state", h, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule